// File: doc/BRIEF.md
# Endpoint Self-Test Command Engine

This block is a register-programmed test engine that sits behind a bus endpoint. A host programs a small bank of 32-bit registers over a simple register bus. One is a scratch word used to prove register access works. The others hold a transfer length in words, a source pointer, a destination pointer, an interrupt kind and an interrupt number. The host then writes a one-hot operation code into the command register. The engine takes the operation and drives a word-wide memory master port to read, fill or copy a block of words, folding every moved word into a 32-bit XOR checksum. It records the outcome as sticky flags in a write-one-to-clear status register. Finally it raises an interrupt request on a request/acknowledge pair.

The control is one state machine with four states. ST_IDLE waits for a pending command. ST_LOAD issues memory reads. ST_STORE issues memory writes. ST_NOTIFY holds the interrupt request until it is acknowledged. The named transitions are:

- take_raise: ST_IDLE to ST_NOTIFY, for an interrupt-only command.
- take_reject: ST_IDLE to ST_NOTIFY, when an address is illegal.
- take_empty: ST_IDLE to ST_NOTIFY, when the length is zero.
- take_load: ST_IDLE to ST_LOAD, for a read or a copy.
- take_store: ST_IDLE to ST_STORE, for a fill.
- load_next: ST_LOAD to ST_LOAD.
- load_to_store: ST_LOAD to ST_STORE, during a copy.
- load_done: ST_LOAD to ST_NOTIFY.
- store_next: ST_STORE to ST_STORE.
- store_to_load: ST_STORE to ST_LOAD, during a copy.
- store_done: ST_STORE to ST_NOTIFY.
- notify_ack: ST_NOTIFY to ST_IDLE.

Top module: `ep_test_ctrl`

## Requirements
- R1: The scratch register at word offset 0 reads back exactly the last 32-bit value written to it.
- R2: After reset every register reads zero, and mem_req and irq_req are low. The word offsets are: 0 scratch, 1 command, 2 status, 3 length, 4 source, 5 destination, 6 interrupt kind, 7 interrupt number, 8 checksum (read-only).
- R3: Command bits are 0 legacy interrupt, 1 MSI, 2 MSI-X, 3 read, 4 fill (write), 5 copy. A written command stays pending and readable while the engine is busy. It reads zero once the engine takes it in ST_IDLE.
- R4: When several command bits are set together, only the lowest-numbered set bit is performed.
- R5: A read fetches length words from source, source+4, and so on. It XORs each returned word into the checksum and then sets status bit 0.
- R6: A fill writes the scratch value sampled at take time, plus the word index, to destination+4*index. It XORs each written word into the checksum and then sets status bit 2.
- R7: A copy reads each word from source+4*i and then writes it to destination+4*i. It XORs each word once and then sets status bit 4.
- R8: An address that is zero or has either of its two low bits set is illegal. Read checks the source, fill checks the destination and copy checks both. An illegal address sets status bit 7 (source) and/or bit 8 (destination), plus the fail bit of the operation: 1 for read, 3 for fill, 5 for copy. The operation then issues no memory access.
- R9: Every read, fill or copy, including a rejected or empty one, ends with irq_req carrying the programmed kind and number. irq_req and its payload are held until irq_ack. Status bit 6 sets on the acknowledge.
- R10: Command bits 0, 1 and 2 raise irq_req with kind 0, 1 and 2 and the programmed number. They leave the transfer flags and the checksum untouched, and set status bit 6 on the acknowledge.
- R11: Writing ones to the status register clears those bits. A bit set by the engine in the same cycle as a clear write ends up set.
- R12: The checksum is cleared when a read, fill or copy is taken. A length of zero performs no memory access and sets the success bit with a checksum of zero.
- R13: mem_req, once raised, stays high with unchanged address, direction and write data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_req | output | 1 | Interrupt request |
| irq_kind | output | 2 | 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 12 | Interrupt vector number |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
Two functions can land in one cycle: the engine setting a status flag, and a host write-one-to-clear on the status register. The bench withholds the interrupt acknowledge and then drives irq_ack together with a status clear of bits 6 and 0 in a single cycle. Bit 6 (set by notify_ack) must survive while bit 0 is cleared. A second collision is a command written while a copy is running: it must stay pending, readable, and then run after the copy finishes.

// File: rtl/ept_pkg.sv
package ept_pkg;
    localparam int OP_N = 6;
    localparam int ST_N = 9;

    localparam logic [3:0] OFF_SCRATCH = 4'd0;
    localparam logic [3:0] OFF_CMD     = 4'd1;
    localparam logic [3:0] OFF_STS     = 4'd2;
    localparam logic [3:0] OFF_LEN     = 4'd3;
    localparam logic [3:0] OFF_SRC     = 4'd4;
    localparam logic [3:0] OFF_DST     = 4'd5;
    localparam logic [3:0] OFF_IKIND   = 4'd6;
    localparam logic [3:0] OFF_INUM    = 4'd7;
    localparam logic [3:0] OFF_CSUM    = 4'd8;

    localparam logic [2:0] OPB_LEG   = 3'd0;
    localparam logic [2:0] OPB_MSI   = 3'd1;
    localparam logic [2:0] OPB_MSIX  = 3'd2;
    localparam logic [2:0] OPB_READ  = 3'd3;
    localparam logic [2:0] OPB_FILL  = 3'd4;
    localparam logic [2:0] OPB_COPY  = 3'd5;

    localparam int SB_RD_OK   = 0;
    localparam int SB_RD_FAIL = 1;
    localparam int SB_WR_OK   = 2;
    localparam int SB_WR_FAIL = 3;
    localparam int SB_CP_OK   = 4;
    localparam int SB_CP_FAIL = 5;
    localparam int SB_IRQ     = 6;
    localparam int SB_BAD_SRC = 7;
    localparam int SB_BAD_DST = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STORE,
        ST_NOTIFY
    } eng_state_e;

    typedef enum logic [1:0] {
        XF_READ,
        XF_FILL,
        XF_COPY
    } xfer_e;
endpackage

// File: rtl/ept_addr_check.sv
module ept_addr_check #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] addr,
    output logic          bad
);
    always_comb begin
        bad = (addr == '0) || (addr[1:0] != 2'b00);
    end
endmodule

// File: rtl/ept_regs.sv
module ept_regs
    import ept_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NUMW = 12,
    parameter int RAW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [DW-1:0]   csum_in,
    input  logic            cmd_take,
    input  logic [ST_N-1:0] sts_set,
    output logic [DW-1:0]   scratch,
    output logic [OP_N-1:0] cmd,
    output logic [DW-1:0]   len,
    output logic [DW-1:0]   src,
    output logic [DW-1:0]   dst,
    output logic [1:0]      ikind,
    output logic [NUMW-1:0] inum
);
    logic [ST_N-1:0] sts_q;
    logic [ST_N-1:0] w1c;
    logic            wr_cmd;

    always_comb begin
        wr_cmd = reg_wr && (reg_addr == OFF_CMD);
        w1c    = (reg_wr && (reg_addr == OFF_STS)) ? reg_wdata[ST_N-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch <= '0;
            cmd     <= '0;
            sts_q   <= '0;
            len     <= '0;
            src     <= '0;
            dst     <= '0;
            ikind   <= '0;
            inum    <= '0;
        end else begin
            sts_q <= (sts_q & ~w1c) | sts_set;
            if (cmd_take) begin
                cmd <= '0;
            end
            if (wr_cmd) begin
                cmd <= reg_wdata[OP_N-1:0];
            end
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_SCRATCH: scratch <= reg_wdata;
                    OFF_LEN:     len     <= reg_wdata;
                    OFF_SRC:     src     <= reg_wdata;
                    OFF_DST:     dst     <= reg_wdata;
                    OFF_IKIND:   ikind   <= reg_wdata[1:0];
                    OFF_INUM:    inum    <= reg_wdata[NUMW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_SCRATCH: reg_rdata = scratch;
            OFF_CMD:     reg_rdata = {{(DW-OP_N){1'b0}}, cmd};
            OFF_STS:     reg_rdata = {{(DW-ST_N){1'b0}}, sts_q};
            OFF_LEN:     reg_rdata = len;
            OFF_SRC:     reg_rdata = src;
            OFF_DST:     reg_rdata = dst;
            OFF_IKIND:   reg_rdata = {{(DW-2){1'b0}}, ikind};
            OFF_INUM:    reg_rdata = {{(DW-NUMW){1'b0}}, inum};
            OFF_CSUM:    reg_rdata = csum_in;
            default:     reg_rdata = '0;
        endcase
    end

    // R3: a taken command is gone next cycle unless the host rewrites it
    a_r3_cmd_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !wr_cmd) |=> (cmd == '0));

    // R11: an engine-set flag is visible next cycle even under a clear write
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts_set) |=> ((sts_q & $past(sts_set)) == $past(sts_set)));
endmodule

// File: rtl/ept_engine.sv
module ept_engine
    import ept_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NUMW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_N-1:0] cmd,
    input  logic [DW-1:0]   scratch,
    input  logic [DW-1:0]   len,
    input  logic [DW-1:0]   src,
    input  logic [DW-1:0]   dst,
    input  logic [1:0]      ikind,
    input  logic [NUMW-1:0] inum,
    output logic            cmd_take,
    output logic [ST_N-1:0] sts_set,
    output logic [DW-1:0]   csum,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            irq_req,
    output logic [1:0]      irq_kind,
    output logic [NUMW-1:0] irq_num,
    input  logic            irq_ack
);
    localparam logic [DW-1:0] WSTEP = DW'(4);
    localparam logic [DW-1:0] ONE   = DW'(1);

    eng_state_e      state_q, state_d;
    xfer_e           op_q;
    logic [DW-1:0]   rd_ptr, wr_ptr, left, idx, seed, hold, csum_q;
    logic [1:0]      kind_q;
    logic [NUMW-1:0] num_q;
    logic [2:0]      pick;
    logic            has_cmd, is_xfer, bad_src, bad_dst, bad_now, last;
    logic [DW-1:0]   fill_word;

    ept_addr_check #(.DW(DW)) u_chk_src (.addr(src), .bad(bad_src));
    ept_addr_check #(.DW(DW)) u_chk_dst (.addr(dst), .bad(bad_dst));

    always_comb begin
        pick = '0;
        for (int i = OP_N - 1; i >= 0; i--) begin
            if (cmd[i]) pick = 3'(i);
        end
        has_cmd = |cmd;
        is_xfer = (pick >= OPB_READ);
        unique case (pick)
            OPB_READ: bad_now = bad_src;
            OPB_FILL: bad_now = bad_dst;
            OPB_COPY: bad_now = bad_src | bad_dst;
            default:  bad_now = 1'b0;
        endcase
        last      = (left == ONE);
        fill_word = seed + idx;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (has_cmd) begin
                    if (!is_xfer || bad_now || (len == '0)) state_d = ST_NOTIFY;
                    else if (pick == OPB_FILL)               state_d = ST_STORE;
                    else                                     state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (mem_ack) begin
                    if (op_q == XF_COPY) state_d = ST_STORE;
                    else if (last)       state_d = ST_NOTIFY;
                end
            end
            ST_STORE: begin
                if (mem_ack) begin
                    if (last)                 state_d = ST_NOTIFY;
                    else if (op_q == XF_COPY) state_d = ST_LOAD;
                end
            end
            ST_NOTIFY: begin
                if (irq_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_LOAD) || (state_q == ST_STORE);
        mem_we    = (state_q == ST_STORE);
        mem_addr  = (state_q == ST_STORE) ? wr_ptr : rd_ptr;
        mem_wdata = (op_q == XF_COPY) ? hold : fill_word;
        irq_req   = (state_q == ST_NOTIFY);
        irq_kind  = kind_q;
        irq_num   = num_q;
        csum      = csum_q;
        cmd_take  = (state_q == ST_IDLE) && has_cmd;
        sts_set   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (has_cmd && is_xfer) begin
                    if (bad_now) begin
                        if (pick != OPB_FILL && bad_src) sts_set[SB_BAD_SRC] = 1'b1;
                        if (pick != OPB_READ && bad_dst) sts_set[SB_BAD_DST] = 1'b1;
                        if (pick == OPB_READ)      sts_set[SB_RD_FAIL] = 1'b1;
                        else if (pick == OPB_FILL) sts_set[SB_WR_FAIL] = 1'b1;
                        else                       sts_set[SB_CP_FAIL] = 1'b1;
                    end else if (len == '0) begin
                        if (pick == OPB_READ)      sts_set[SB_RD_OK] = 1'b1;
                        else if (pick == OPB_FILL) sts_set[SB_WR_OK] = 1'b1;
                        else                       sts_set[SB_CP_OK] = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (mem_ack && last && op_q == XF_READ) sts_set[SB_RD_OK] = 1'b1;
            end
            ST_STORE: begin
                if (mem_ack && last) begin
                    if (op_q == XF_COPY) sts_set[SB_CP_OK] = 1'b1;
                    else                 sts_set[SB_WR_OK] = 1'b1;
                end
            end
            ST_NOTIFY: begin
                if (irq_ack) sts_set[SB_IRQ] = 1'b1;
            end
            default: ;
        endcase
    end

    // transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= XF_READ;
            rd_ptr <= '0;
            wr_ptr <= '0;
            left   <= '0;
            idx    <= '0;
            seed   <= '0;
            hold   <= '0;
            csum_q <= '0;
            kind_q <= '0;
            num_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (has_cmd) begin
                        num_q <= inum;
                        if (!is_xfer) begin
                            kind_q <= pick[1:0];
                        end else begin
                            kind_q <= ikind;
                            csum_q <= '0;
                            rd_ptr <= src;
                            wr_ptr <= dst;
                            left   <= len;
                            idx    <= '0;
                            seed   <= scratch;
                            if (pick == OPB_READ)      op_q <= XF_READ;
                            else if (pick == OPB_FILL) op_q <= XF_FILL;
                            else                       op_q <= XF_COPY;
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        csum_q <= csum_q ^ mem_rdata;
                        hold   <= mem_rdata;
                        if (op_q != XF_COPY) begin
                            rd_ptr <= rd_ptr + WSTEP;
                            left   <= left - ONE;
                        end
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        if (op_q == XF_FILL) csum_q <= csum_q ^ fill_word;
                        wr_ptr <= wr_ptr + WSTEP;
                        rd_ptr <= rd_ptr + WSTEP;
                        left   <= left - ONE;
                        idx    <= idx + ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R13: a pending memory access does not change before it is acknowledged
    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R9: the interrupt request and its payload persist until acknowledged
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_kind) && $stable(irq_num)));

    // R8: a rejected command never reaches the memory port
    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && bad_now) |=> !mem_req);

    // R12: the checksum starts from zero for every taken transfer
    a_r12_csum_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && is_xfer) |=> (csum == '0));
endmodule

// File: rtl/ep_test_ctrl.sv
module ep_test_ctrl
    import ept_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NUMW = 12,
    parameter int RAW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            irq_req,
    output logic [1:0]      irq_kind,
    output logic [NUMW-1:0] irq_num,
    input  logic            irq_ack
);
    logic [DW-1:0]   scratch, len, src, dst, csum;
    logic [OP_N-1:0] cmd;
    logic [1:0]      ikind;
    logic [NUMW-1:0] inum;
    logic            cmd_take;
    logic [ST_N-1:0] sts_set;

    ept_regs #(.DW(DW), .NUMW(NUMW), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .csum_in   (csum),
        .cmd_take  (cmd_take),
        .sts_set   (sts_set),
        .scratch   (scratch),
        .cmd       (cmd),
        .len       (len),
        .src       (src),
        .dst       (dst),
        .ikind     (ikind),
        .inum      (inum)
    );

    ept_engine #(.DW(DW), .NUMW(NUMW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .scratch   (scratch),
        .len       (len),
        .src       (src),
        .dst       (dst),
        .ikind     (ikind),
        .inum      (inum),
        .cmd_take  (cmd_take),
        .sts_set   (sts_set),
        .csum      (csum),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .irq_req   (irq_req),
        .irq_kind  (irq_kind),
        .irq_num   (irq_num),
        .irq_ack   (irq_ack)
    );
endmodule

// File: tb/ep_test_ctrl_tb_top.sv
module ep_test_ctrl_tb_top;
    localparam int NUMW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            mem_req, mem_we;
    logic [31:0]     mem_addr, mem_wdata;
    logic            mem_ack = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic            irq_req;
    logic [1:0]      irq_kind;
    logic [NUMW-1:0] irq_num;
    logic            irq_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } mx_t;
    typedef struct { logic [1:0] kind; logic [NUMW-1:0] num; } ix_t;
    mx_t exp_mem[$];
    ix_t exp_irq[$];
    logic [31:0] mem [logic [31:0]];

    bit          auto_irq = 1'b1;
    int          wcnt = 0;
    int          lat_sel = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [1:0]      ikind_sh = '0;
    logic [NUMW-1:0] inum_sh = '0;

    ep_test_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_req(irq_req),
        .irq_kind(irq_kind), .irq_num(irq_num), .irq_ack(irq_ack)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] memval(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    // memory responder and per-access reference comparison
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
            pend = 1'b0;
        end else if (mem_req) begin
            if (pend) chk("R13 address held while waiting", mem_addr, pend_addr);
            pend = 1'b1;
            pend_addr = mem_addr;
            if (wcnt >= lat_sel) begin
                if (exp_mem.size() == 0) begin
                    chk("R8/R12 unexpected memory access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    mx_t e;
                    e = exp_mem.pop_front();
                    chk("R5/R6/R7 access direction", {31'd0, mem_we}, {31'd0, e.we});
                    chk("R5/R6/R7 access address", mem_addr, e.addr);
                    if (e.we) begin
                        chk("R6/R7 write data", mem_wdata, e.data);
                        mem[mem_addr] = mem_wdata;
                    end
                end
                mem_rdata = memval(mem_addr);
                mem_ack = 1'b1;
                lat_sel = (lat_sel + 1) % 3;
            end else begin
                wcnt++;
            end
        end
    end

    // interrupt responder
    always @(negedge clk) begin
        if (auto_irq) begin
            if (irq_ack) begin
                irq_ack = 1'b0;
            end else if (irq_req) begin
                if (exp_irq.size() == 0) begin
                    chk("R9/R10 unexpected interrupt", {30'd0, irq_kind}, 32'hFFFF_FFFF);
                end else begin
                    ix_t x;
                    x = exp_irq.pop_front();
                    chk("R9/R10 interrupt kind", {30'd0, irq_kind}, {30'd0, x.kind});
                    chk("R9/R10 interrupt number", 32'(irq_num), 32'(x.num));
                end
                irq_ack = 1'b1;
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (exp_mem.size() == 0 && exp_irq.size() == 0 && !irq_req && !irq_ack) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic push_irq(logic [1:0] k, logic [NUMW-1:0] n);
        ix_t x;
        x.kind = k; x.num = n;
        exp_irq.push_back(x);
    endtask

    function automatic logic [31:0] plan_read(logic [31:0] s, int n);
        logic [31:0] c = '0;
        for (int i = 0; i < n; i++) begin
            mx_t e;
            e.we = 1'b0; e.addr = s + 32'(4 * i); e.data = '0;
            exp_mem.push_back(e);
            c ^= memval(e.addr);
        end
        return c;
    endfunction

    function automatic logic [31:0] plan_fill(logic [31:0] d, int n, logic [31:0] seed);
        logic [31:0] c = '0;
        for (int i = 0; i < n; i++) begin
            mx_t e;
            e.we = 1'b1; e.addr = d + 32'(4 * i); e.data = seed + 32'(i);
            exp_mem.push_back(e);
            c ^= e.data;
        end
        return c;
    endfunction

    function automatic logic [31:0] plan_copy(logic [31:0] s, logic [31:0] d, int n);
        logic [31:0] c = '0;
        for (int i = 0; i < n; i++) begin
            mx_t r, w;
            r.we = 1'b0; r.addr = s + 32'(4 * i); r.data = '0;
            w.we = 1'b1; w.addr = d + 32'(4 * i); w.data = memval(r.addr);
            exp_mem.push_back(r);
            exp_mem.push_back(w);
            c ^= w.data;
        end
        return c;
    endfunction

    task automatic setkind(logic [1:0] k, logic [NUMW-1:0] n);
        wr(4'd6, {30'd0, k});
        wr(4'd7, 32'(n));
        ikind_sh = k;
        inum_sh = n;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, ec, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state of every register and of the request outputs
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            chk($sformatf("R2 reset value at offset %0d", a), v, 32'd0);
        end
        chk("R2 mem_req low after reset", {31'd0, mem_req}, 32'd0);
        chk("R2 irq_req low after reset", {31'd0, irq_req}, 32'd0);

        // R1: scratch read-back
        wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, v); chk("R1 scratch pattern A", v, 32'hDEAD_BEEF);
        wr(4'd0, 32'h0123_4567); rd(4'd0, v); chk("R1 scratch pattern B", v, 32'h0123_4567);

        setkind(2'd1, 12'd5);

        // R5: read of four words
        wr(4'd4, 32'h100); wr(4'd3, 32'd4);
        ec = plan_read(32'h100, 4);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h08);
        wait_idle();
        rd(4'd2, v); chk("R5 R9 status after read", v, 32'h041);
        rd(4'd8, v); chk("R5 read checksum", v, ec);
        rd(4'd1, v); chk("R3 command cleared after take", v, 32'd0);
        wr(4'd2, 32'h1FF); rd(4'd2, v); chk("R11 write-one clear of status", v, 32'd0);

        // R6: fill of three words with scratch seed
        wr(4'd0, 32'h1000_0000); wr(4'd5, 32'h200); wr(4'd3, 32'd3);
        ec = plan_fill(32'h200, 3, 32'h1000_0000);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h10);
        wait_idle();
        rd(4'd2, v); chk("R6 status after fill", v, 32'h044);
        rd(4'd8, v); chk("R6 fill checksum", v, ec);
        wr(4'd2, 32'h1FF);

        // R7: copy the filled block elsewhere
        setkind(2'd2, 12'h7FF);
        wr(4'd4, 32'h200); wr(4'd5, 32'h300);
        ec = plan_copy(32'h200, 32'h300, 3);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h20);
        wait_idle();
        rd(4'd2, v); chk("R7 status after copy", v, 32'h050);
        rd(4'd8, v); chk("R7 copy checksum", v, ec);
        chk("R7 destination word 2 copied", memval(32'h308), 32'h1000_0002);
        wr(4'd2, 32'h1FF);

        // R4 R10: legacy bit beats read bit; checksum untouched
        rd(4'd8, prev);
        push_irq(2'd0, inum_sh);
        wr(4'd1, 32'h09);
        wait_idle();
        rd(4'd2, v); chk("R4 R10 status after legacy raise", v, 32'h040);
        rd(4'd8, v); chk("R10 checksum untouched by raise", v, prev);
        wr(4'd2, 32'h1FF);

        // R10: MSI-X raise
        push_irq(2'd2, inum_sh);
        wr(4'd1, 32'h04);
        wait_idle();
        rd(4'd2, v); chk("R10 status after MSI-X raise", v, 32'h040);
        wr(4'd2, 32'h1FF);

        // R4: read bit beats fill and copy bits
        wr(4'd4, 32'h100); wr(4'd3, 32'd2);
        ec = plan_read(32'h100, 2);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h38);
        wait_idle();
        rd(4'd2, v); chk("R4 read chosen over fill and copy", v, 32'h041);
        rd(4'd8, v); chk("R4 checksum of chosen read", v, ec);
        wr(4'd2, 32'h1FF);

        // R8: illegal addresses
        wr(4'd4, 32'h0);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h08);
        wait_idle();
        rd(4'd2, v); chk("R8 read with zero source", v, 32'h0C2);
        rd(4'd8, v); chk("R12 checksum cleared on rejected read", v, 32'd0);
        wr(4'd2, 32'h1FF);
        wr(4'd5, 32'h201);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h10);
        wait_idle();
        rd(4'd2, v); chk("R8 fill with unaligned destination", v, 32'h148);
        wr(4'd2, 32'h1FF);
        wr(4'd4, 32'h3); wr(4'd5, 32'h0);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h20);
        wait_idle();
        rd(4'd2, v); chk("R8 copy with both addresses illegal", v, 32'h1E0);
        wr(4'd2, 32'h1FF);

        // R12: zero length completes at once
        wr(4'd4, 32'h100); wr(4'd3, 32'd0);
        push_irq(ikind_sh, inum_sh);
        wr(4'd1, 32'h08);
        wait_idle();
        rd(4'd2, v); chk("R12 zero length read succeeds", v, 32'h041);
        rd(4'd8, v); chk("R12 zero length checksum", v, 32'd0);
        wr(4'd2, 32'h1FF);

        // R3: a command written while busy stays pending and runs afterwards
        setkind(2'd0, 12'd9);
        wr(4'd4, 32'h100); wr(4'd5, 32'h400); wr(4'd3, 32'd3);
        ec = plan_copy(32'h100, 32'h400, 3);
        push_irq(ikind_sh, inum_sh);
        push_irq(2'd1, inum_sh);
        wr(4'd1, 32'h20);
        wr(4'd1, 32'h02);
        rd(4'd1, v); chk("R3 command pending while busy", v, 32'h02);
        wait_idle();
        rd(4'd1, v); chk("R3 pending command taken after copy", v, 32'd0);
        rd(4'd2, v); chk("R3 R7 status after copy and raise", v, 32'h050);
        rd(4'd8, v); chk("R7 checksum of second copy", v, ec);
        wr(4'd2, 32'h1FF);

        // R11: status clear in the same cycle as the acknowledge that sets bit 6
        auto_irq = 1'b0;
        wr(4'd4, 32'h100); wr(4'd3, 32'd1);
        ec = plan_read(32'h100, 1);
        wr(4'd1, 32'h08);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (irq_req) break;
        end
        chk("R9 interrupt request held without acknowledge", {31'd0, irq_req}, 32'd1);
        chk("R9 interrupt kind on completion", {30'd0, irq_kind}, {30'd0, ikind_sh});
        repeat (3) @(negedge clk);
        chk("R9 request still held", {31'd0, irq_req}, 32'd1);
        irq_ack = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h041;
        @(negedge clk);
        irq_ack = 1'b0; reg_wr = 1'b0;
        rd(4'd2, v); chk("R11 set wins over same-cycle clear", v, 32'h040);
        chk("R9 request dropped after acknowledge", {31'd0, irq_req}, 32'd0);
        auto_irq = 1'b1;

        chk("R5 R6 R7 no leftover memory expectations", 32'(exp_mem.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule